// File: doc/BRIEF.md
# Four-Channel Quadrant-Spread Pulse Width Modulator

This block drives four pulse-width modulated outputs from one shared 10-bit up-counter. The counter steps only on cycles where an external prescaler raises a one-cycle enable, so the output frequency follows the prescaler rate. Each channel holds a 10-bit width value `n` and is high for `n+1` counter steps in every 1024-step period.

Each channel can place its high time in one of two ways. In contiguous mode it emits a single pulse that starts at count 0. In spread mode the period is cut into four 256-step quadrants and each quadrant carries roughly a quarter of the high time. This lowers the ripple left after an external low-pass filter.

Software loads each channel through two byte-wide write-only registers. New values are held in a staging copy and take effect only when the counter rolls over, so a period never mixes old and new settings.

Top module: `pwm4_spread`

## Requirements
- R1: One 10-bit counter is shared by all channels and rises by one on each enabled step. It wraps from 1023 to 0, so every period is 1024 steps long.
- R2: When `tick` is low at a clock edge, the counter and all outputs hold their values.
- R3: In contiguous mode (spread bit 0), an output is high exactly when the counter value is at most `n`.
- R4: In spread mode (spread bit 1), quadrant q is counter bits [9:8]. The output is high while counter bits [7:0] are below a per-quadrant count. That count is `n[9:2]` plus one extra step. Quadrant 0 always gets the extra step. Quadrant 2 gets it when `n[1:0]` is not 0. Quadrant 1 gets it when `n[1]` is 1. Quadrant 3 gets it when `n[1:0]` is 3.
- R5: In both modes, every output is high for exactly `n+1` steps per period and is high at count 0.
- R6: A write to address `{ch, 1'b1}` loads `wr_data` into bits [9:2] of channel `ch`'s width. A write to address `{ch, 1'b0}` loads `wr_data[7:6]` into width bits [1:0] and `wr_data[0]` into the spread bit. Bits [5:1] of that byte are ignored.
- R7: Written values reach the active settings only on the step that wraps the counter from 1023 to 0. A write in the middle of a period does not change that period's output.
- R8: After reset the counter is 0, and every channel is active with width 0 in contiguous mode. All outputs are therefore high at count 0 and low at count 1.
- R9: A width of 1023 keeps the output high for the whole period in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Counter step enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | `{channel, high_byte}` register select |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 4 | One output per channel |

## Verification
The bench builds the block with its default parameters: four channels and a 10-bit counter, so one period is 1024 steps. Because the four channels run in parallel, each measured period checks four width and mode pairs at once. This makes it possible to cover the quadrant edge widths (0 to 7, 255/256, 511/512, 767, 1020 to 1023) in both modes within the cycle budget. Directed runs then cover the reset state, a held enable, an enable that is asserted only every other cycle, and a write in the middle of a period.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int CNT_W  = 10;
    localparam int QUAD_W = 2;
    localparam int SUB_W  = CNT_W - QUAD_W;
    localparam int FRAC_W = QUAD_W;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic             spread;
        logic [CNT_W-1:0] width;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign wrap = tick && (&st_q.cnt);

    // R2: no enable, no movement
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    // R1: modulo-1024 step
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(NCH) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  wrap,
    output chan_cfg_t [NCH-1:0]   active
);
    localparam int CH_W = ADDR_W - 1;

    typedef struct packed {
        chan_cfg_t [NCH-1:0] shadow;
        chan_cfg_t [NCH-1:0] active;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            if (wr_en && (wr_addr[ADDR_W-1:1] == CH_W'(i))) begin
                if (wr_addr[0]) begin
                    st_d.shadow[i].width[CNT_W-1:FRAC_W] = wr_data;
                end else begin
                    st_d.shadow[i].width[FRAC_W-1:0] = wr_data[BYTE_W-1 -: FRAC_W];
                    st_d.shadow[i].spread            = wr_data[0];
                end
            end
        end
        if (wrap) st_d.active = st_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    logic unused_mid_bits;
    assign unused_mid_bits = ^wr_data[BYTE_W-FRAC_W-1:1];

    // R7: active settings move only on the wrap step
    assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(active));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  chan_cfg_t        cfg,
    output logic             pwm
);
    logic [QUAD_W-1:0] quad;
    logic [SUB_W-1:0]  sub;
    logic [SUB_W-1:0]  base;
    logic [FRAC_W-1:0] frac;
    logic              extra;
    logic [SUB_W:0]    quad_hi;

    always_comb begin
        quad = cnt[CNT_W-1:SUB_W];
        sub  = cnt[SUB_W-1:0];
        base = cfg.width[CNT_W-1:FRAC_W];
        frac = cfg.width[FRAC_W-1:0];
        case (quad)
            2'd0:    extra = 1'b1;
            2'd1:    extra = frac[1];
            2'd2:    extra = |frac;
            default: extra = &frac;
        endcase
        quad_hi = {1'b0, base} + {{SUB_W{1'b0}}, extra};
        if (cfg.spread) pwm = ({1'b0, sub} < quad_hi);
        else            pwm = (cnt <= cfg.width);
    end

    // R5: every width is high at the start of a period
    assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> pwm);
    // R9: full-scale width never drops
    assert_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&cfg.width) |-> pwm);
endmodule

// File: rtl/pwm4_spread.sv
module pwm4_spread
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(NCH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_out
);
    logic [CNT_W-1:0]    cnt;
    logic                wrap;
    chan_cfg_t [NCH-1:0] active;

    pwm_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wrap    (wrap),
        .active  (active)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt),
            .cfg   (active[g]),
            .pwm   (pwm_out[g])
        );
    end
endmodule

// File: tb/pwm4_spread_test.sv
`timescale 1ns/1ps
module pwm4_spread_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_out;

    pwm4_spread uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    int pos = 0;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit meas = 1'b0;
    int hq[4][4];
    int cur_n[4];
    bit cur_sp[4];

    // {width(10), spread(1), expected total for channel 0 (11)}
    localparam logic [21:0] VEC [20] = '{
        {10'd0,    1'b0, 11'd1},    {10'd0,    1'b1, 11'd1},
        {10'd1,    1'b1, 11'd2},    {10'd2,    1'b1, 11'd3},
        {10'd3,    1'b1, 11'd4},    {10'd4,    1'b1, 11'd5},
        {10'd5,    1'b0, 11'd6},    {10'd6,    1'b1, 11'd7},
        {10'd7,    1'b0, 11'd8},    {10'd255,  1'b1, 11'd256},
        {10'd256,  1'b0, 11'd257},  {10'd511,  1'b1, 11'd512},
        {10'd512,  1'b0, 11'd513},  {10'd767,  1'b1, 11'd768},
        {10'd1020, 1'b1, 11'd1021}, {10'd1021, 1'b0, 11'd1022},
        {10'd1022, 1'b1, 11'd1023}, {10'd1023, 1'b0, 11'd1024},
        {10'd1023, 1'b1, 11'd1024}, {10'd383,  1'b1, 11'd384}
    };

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cycles);
                summary();
                $finish;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_q(input int n, input bit sp, input int q);
        int b, f, r;
        b = n / 4;
        f = n % 4;
        if (sp) begin
            if (q == 0)      r = b + 1;
            else if (q == 1) r = b + ((f >= 2) ? 1 : 0);
            else if (q == 2) r = b + ((f >= 1) ? 1 : 0);
            else             r = b + ((f == 3) ? 1 : 0);
        end else begin
            r = n + 1 - q * 256;
            if (r < 0)   r = 0;
            if (r > 256) r = 256;
        end
        return r;
    endfunction

    // One clock: sample at the falling edge, drive, then settle past the rising edge
    task automatic cyc(input bit t, input bit we, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        if (meas && t)
            for (int c = 0; c < 4; c++) if (pwm_out[c]) hq[c][pos / 256]++;
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (t) pos = (pos + 1) % 1024;
        #2;
    endtask

    function automatic logic [7:0] lo_byte(input int n, input bit sp);
        logic [9:0] w;
        w = 10'(n);
        return {w[1:0], 5'b10101, sp}; // R6: middle bits must be ignored
    endfunction

    function automatic logic [7:0] hi_byte(input int n);
        logic [9:0] w;
        w = 10'(n);
        return w[9:2];
    endfunction

    task automatic set_ch(input int ch, input int n, input bit sp);
        cyc(1'b1, 1'b1, {2'(ch), 1'b0}, lo_byte(n, sp));
        cyc(1'b1, 1'b1, {2'(ch), 1'b1}, hi_byte(n));
    endtask

    task automatic to_wrap();
        while (pos != 0) cyc(1'b1, 1'b0, 3'd0, 8'd0);
    endtask

    task automatic measure(input bit sparse, input bit do_wr, input int wch, input int wn, input bit wsp);
        for (int c = 0; c < 4; c++) for (int q = 0; q < 4; q++) hq[c][q] = 0;
        meas = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            if (sparse) cyc(1'b0, 1'b0, 3'd0, 8'd0);
            if (do_wr && i == 512)      cyc(1'b1, 1'b1, {2'(wch), 1'b0}, lo_byte(wn, wsp));
            else if (do_wr && i == 513) cyc(1'b1, 1'b1, {2'(wch), 1'b1}, hi_byte(wn));
            else                        cyc(1'b1, 1'b0, 3'd0, 8'd0);
        end
        meas = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++) begin
            int tot;
            tot = 0;
            for (int q = 0; q < 4; q++) begin
                tot += hq[c][q];
                chk($sformatf("%s %s ch%0d n=%0d q%0d", tag, cur_sp[c] ? "R4" : "R3", c, cur_n[c], q),
                    hq[c][q], exp_q(cur_n[c], cur_sp[c], q));
            end
            chk($sformatf("%s R5 ch%0d n=%0d total", tag, c, cur_n[c]), tot, cur_n[c] + 1);
            if (cur_n[c] == 1023)
                chk($sformatf("%s R9 ch%0d full period", tag, c), tot, 1024);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R8: reset state, count 0
        chk("R8 outputs at count 0", int'(pwm_out), 15);
        // R2: enable held low keeps count 0 and outputs high
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 1'b0, 3'd0, 8'd0);
            chk("R2 hold with tick low", int'(pwm_out), 15);
        end
        cyc(1'b1, 1'b0, 3'd0, 8'd0);
        chk("R8 outputs at count 1", int'(pwm_out), 0);
        for (int k = 0; k < 4; k++) begin cur_n[k] = 0; cur_sp[k] = 1'b0; end
        to_wrap();
        measure(1'b0, 1'b0, 0, 0, 1'b0);
        check_all("R8 reset period R1");

        // table walk: R3 R4 R5 R6 R9
        for (int v = 0; v < 20; v++) begin
            int n0;
            bit s0;
            n0 = int'(VEC[v][21:12]);
            s0 = VEC[v][11];
            for (int c = 0; c < 4; c++) begin
                cur_n[c] = (n0 + c * 257) % 1024;
                cur_sp[c] = s0 ^ c[0];
                set_ch(c, cur_n[c], cur_sp[c]);
            end
            to_wrap();
            measure(1'b0, 1'b0, 0, 0, 1'b0);
            check_all($sformatf("vec%0d R6", v));
            chk($sformatf("vec%0d R5 table total", v), hq[0][0] + hq[0][1] + hq[0][2] + hq[0][3],
                int'(VEC[v][10:0]));
        end

        // R7: mid-period write is held until the wrap
        to_wrap();
        set_ch(0, 300, 1'b0);
        to_wrap();
        cur_n[0] = 300; cur_sp[0] = 1'b0;
        measure(1'b0, 1'b1, 0, 701, 1'b1);
        check_all("R7 old value period");
        cur_n[0] = 701; cur_sp[0] = 1'b1;
        measure(1'b0, 1'b0, 0, 0, 1'b0);
        check_all("R7 new value period");

        // R2: sparse enable gives the same per-step counts
        measure(1'b1, 1'b0, 0, 0, 1'b0);
        check_all("R2 sparse tick");

        summary();
        $finish;
    end
endmodule